// File: doc/BRIEF.md
# Retransmission Descriptor Manager

This block tracks a circular window of buffered data packets on the sending side of a reliable link that runs over an unreliable network. It holds one descriptor per buffer slot, not the packet data. A descriptor records the set number the slot was filled for, and three flags: filled and waiting, transmitted at least once, and acknowledged by the far end. A data producer fills slots in order through a request/grant pair. The block receives acknowledges as a (set, slot) pair from a control-frame parser. It tells a frame sender which slot to transmit next, and whether that transmission repeats an earlier one. The frame sender can feed that flag into its inter-packet delay adaptation.

Any slot that is filled but not yet acknowledged is offered again and again in cyclic order, so lost packets are repeated without a separate timer. Acknowledged slots are released in slot order by a tail pointer. A released slot can then take the packet at the same position in the following set. A start pulse wipes the window and begins a fresh run at slot 0, set 0. A stop pulse halts filling and sending but keeps the descriptors.

Top module: `retx_desc_mgr`

## Requirements
- R1: After reset the block is not running: `running_o`, `fill_gnt_o` and `snd_vld_o` are 0.
- R2: In the cycle after a start pulse, every descriptor is empty, the fill pointer is slot 0 with set 0, the block is running, `fill_gnt_o` is 1 and `snd_vld_o` is 0.
- R3: While running, `fill_gnt_o` is 1 exactly when the slot at the fill pointer is empty. `fill_slot_o` and `fill_set_o` show that slot and the current set. An accepted fill (`fill_req_i` and `fill_gnt_o`) marks the slot filled, not sent and not confirmed, and moves the pointer by one. When the pointer wraps from the last slot to slot 0, the set number increments modulo 2^SET_W.
- R4: While running, `snd_vld_o` is 1 when any slot is filled and unconfirmed. `snd_slot_o` is the first such slot in cyclic order, starting one past the last slot handed over (slot 0 after a start). `snd_set_o` is that slot's set number.
- R5: `snd_retx_o` is 1 exactly when the offered slot has already been handed over at least once since it was filled.
- R6: An acknowledge confirms the named slot only if that slot is filled and its stored set number equals `ack_set_i`. Any other acknowledge is ignored, and the slot stays on offer.
- R7: If the slot at the tail pointer is filled and confirmed, it is emptied and the tail moves one slot. This happens at most once per cycle, whether running or stopped. An emptied slot becomes grantable again when the fill pointer reaches it.
- R8: In the cycle after a stop pulse (without start), `fill_gnt_o` and `snd_vld_o` are 0. Descriptors are kept, and acknowledges and tail release still take effect.
- R9: When start and stop arrive in the same cycle, start wins.
- R10: A slot is handed over only in a cycle where `snd_vld_o` and `snd_rdy_i` are both 1. Without that, the offer stays on the same slot as long as no fill, acknowledge, start or stop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: clear the window and run |
| stop_i | input | 1 | Stop pulse: halt filling and sending |
| running_o | output | 1 | Run state |
| fill_req_i | input | 1 | Producer has a packet for the offered slot |
| fill_gnt_o | output | 1 | Offered slot is empty and may be filled |
| fill_slot_o | output | IDX_W | Slot at the fill pointer |
| fill_set_o | output | SET_W | Set number the filled packet belongs to |
| ack_vld_i | input | 1 | Acknowledge strobe |
| ack_set_i | input | SET_W | Acknowledged set number |
| ack_slot_i | input | IDX_W | Acknowledged slot |
| snd_rdy_i | input | 1 | Sender accepts the offered slot |
| snd_vld_o | output | 1 | A slot is offered for transmission |
| snd_slot_o | output | IDX_W | Offered slot |
| snd_set_o | output | SET_W | Set number of the offered slot |
| snd_retx_o | output | 1 | Offered slot is a repeat transmission |

## Verification
The bench targets stale acknowledges, meaning those with a wrong set or those aimed at a slot that a restart has cleared. A manager that ignored the set would silently drop a packet, and the bench would see the slot vanish from the send offer too early. It also drives dropped acknowledges, so slots are offered again. A design that lost the sent flag, or that restarted its scan at slot 0 instead of after the last slot handed over, would show a wrong repeat flag or a wrong slot order. Fill-pointer wraps across many sets check the set increment. Stop and start pulses, including both together, check that stopping keeps state and that starting wipes it.

// File: rtl/retx_desc_mgr.sv
module retx_desc_mgr #(
  parameter int SLOTS = 32,
  parameter int SET_W = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             running_o,
  input  logic             fill_req_i,
  output logic             fill_gnt_o,
  output logic [IDX_W-1:0] fill_slot_o,
  output logic [SET_W-1:0] fill_set_o,
  input  logic             ack_vld_i,
  input  logic [SET_W-1:0] ack_set_i,
  input  logic [IDX_W-1:0] ack_slot_i,
  input  logic             snd_rdy_i,
  output logic             snd_vld_o,
  output logic [IDX_W-1:0] snd_slot_o,
  output logic [SET_W-1:0] snd_set_o,
  output logic             snd_retx_o
);

  typedef struct packed {
    logic             full;
    logic             sent;
    logic             conf;
    logic [SET_W-1:0] set;
  } desc_t;

  desc_t            d_q [SLOTS];
  logic [IDX_W-1:0] head_q, tail_q, last_q;
  logic [SET_W-1:0] fset_q;
  logic             run_q;

  logic             pick_ok;
  logic [IDX_W-1:0] pick, idx;
  logic             fill_fire, snd_fire, tail_free;

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    idx     = '0;
    for (int k = 1; k <= SLOTS; k++) begin
      idx = last_q + IDX_W'(k);
      if (!pick_ok && d_q[idx].full && !d_q[idx].conf) begin
        pick_ok = 1'b1;
        pick    = idx;
      end
    end
  end

  assign running_o   = run_q;
  assign fill_slot_o = head_q;
  assign fill_set_o  = fset_q;
  assign fill_gnt_o  = run_q && !d_q[head_q].full;
  assign fill_fire   = fill_req_i && fill_gnt_o;
  assign snd_vld_o   = run_q && pick_ok;
  assign snd_slot_o  = pick;
  assign snd_set_o   = d_q[pick].set;
  assign snd_retx_o  = d_q[pick].sent;
  assign snd_fire    = snd_vld_o && snd_rdy_i;
  assign tail_free   = d_q[tail_q].full && d_q[tail_q].conf;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit_fill, hit_free, hit_snd, hit_ack;
    assign hit_fill = fill_fire && head_q == IDX_W'(g);
    assign hit_free = tail_free && tail_q == IDX_W'(g);
    assign hit_snd  = snd_fire && pick == IDX_W'(g);
    assign hit_ack  = ack_vld_i && ack_slot_i == IDX_W'(g) &&
                      d_q[g].full && d_q[g].set == ack_set_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[g] <= '0;
      end else if (start_i) begin
        d_q[g] <= '0;
      end else if (hit_fill) begin
        d_q[g] <= '{full: 1'b1, sent: 1'b0, conf: 1'b0, set: fset_q};
      end else if (hit_free) begin
        d_q[g].full <= 1'b0;
        d_q[g].sent <= 1'b0;
        d_q[g].conf <= 1'b0;
      end else begin
        if (hit_snd) d_q[g].sent <= 1'b1;
        if (hit_ack) d_q[g].conf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      last_q <= '1;
      fset_q <= '0;
      run_q  <= 1'b0;
    end else if (start_i) begin
      head_q <= '0;
      tail_q <= '0;
      last_q <= '1;
      fset_q <= '0;
      run_q  <= 1'b1;
    end else begin
      if (stop_i) run_q <= 1'b0;
      if (fill_fire) begin
        head_q <= head_q + 1'b1;
        if (head_q == '1) fset_q <= fset_q + 1'b1;
      end
      if (tail_free) tail_q <= tail_q + 1'b1;
      if (snd_fire) last_q <= pick;
    end
  end

endmodule

// File: rtl/retx_desc_mgr_chk.sv
module retx_desc_mgr_chk #(
  parameter int IDX_W = 5,
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             running_o,
  input logic             fill_req_i,
  input logic             fill_gnt_o,
  input logic [IDX_W-1:0] fill_slot_o,
  input logic [SET_W-1:0] fill_set_o,
  input logic             ack_vld_i,
  input logic             snd_rdy_i,
  input logic             snd_vld_o,
  input logic [IDX_W-1:0] snd_slot_o
);

  // R2
  start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> running_o && fill_gnt_o && fill_slot_o == '0 &&
                fill_set_o == '0 && !snd_vld_o);

  // R3
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_i && fill_gnt_o && !start_i |=>
      fill_slot_o == IDX_W'($past(fill_slot_o) + 1'b1));

  // R3
  set_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_i && fill_gnt_o && !start_i && fill_slot_o == '1 |=>
      fill_set_o == SET_W'($past(fill_set_o) + 1'b1));

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !fill_gnt_o && !snd_vld_o && !running_o);

  // R9
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && stop_i |=> running_o);

  // R10
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_vld_o && !snd_rdy_i && !start_i && !stop_i && !fill_req_i && !ack_vld_i
      |=> snd_vld_o && $stable(snd_slot_o));

endmodule

bind retx_desc_mgr retx_desc_mgr_chk #(.IDX_W(IDX_W), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .running_o(running_o), .fill_req_i(fill_req_i), .fill_gnt_o(fill_gnt_o),
  .fill_slot_o(fill_slot_o), .fill_set_o(fill_set_o), .ack_vld_i(ack_vld_i),
  .snd_rdy_i(snd_rdy_i), .snd_vld_o(snd_vld_o), .snd_slot_o(snd_slot_o)
);

// File: tb/sim_retx_desc_mgr.sv
`timescale 1ns/1ps
module sim_retx_desc_mgr;
  localparam int SLOTS = 32;
  localparam int SET_W = 4;
  localparam int IDX_W = 5;
  localparam int SETS  = 1 << SET_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, fill_req_i = 0, ack_vld_i = 0, snd_rdy_i = 0;
  logic [SET_W-1:0] ack_set_i = '0;
  logic [IDX_W-1:0] ack_slot_i = '0;
  logic running_o, fill_gnt_o, snd_vld_o, snd_retx_o;
  logic [IDX_W-1:0] fill_slot_o, snd_slot_o;
  logic [SET_W-1:0] fill_set_o, snd_set_o;

  always #2 clk = ~clk;

  retx_desc_mgr #(.SLOTS(SLOTS), .SET_W(SET_W)) u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  int mf[SLOTS], ms[SLOTS], mc[SLOTS], mset[SLOTS];
  int mh = 0, mt = 0, mfs = 0, ml = SLOTS - 1, mr = 0;
  int ackq[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_pick();
    for (int k = 1; k <= SLOTS; k++) begin
      int i = (ml + k) % SLOTS;
      if (mf[i] != 0 && mc[i] == 0) return i;
    end
    return -1;
  endfunction

  task automatic compare();
    int p = ref_pick();
    int ev = (mr != 0 && p >= 0) ? 1 : 0;
    chk("R1/R8/R9 running_o", int'(running_o), mr);
    chk("R3/R7/R8 fill_gnt_o", int'(fill_gnt_o), (mr != 0 && mf[mh] == 0) ? 1 : 0);
    chk("R2/R3 fill_slot_o", int'(fill_slot_o), mh);
    chk("R2/R3 fill_set_o", int'(fill_set_o), mfs);
    chk("R4/R6 snd_vld_o", int'(snd_vld_o), ev);
    if (ev != 0) begin
      chk("R4/R10 snd_slot_o", int'(snd_slot_o), p);
      chk("R4 snd_set_o", int'(snd_set_o), mset[p]);
      chk("R5 snd_retx_o", int'(snd_retx_o), ms[p]);
    end
  endtask

  task automatic step();
    int p = ref_pick();
    bit gnt = (mr != 0 && mf[mh] == 0);
    bit ffire = fill_req_i && gnt;
    bit sfire = (mr != 0 && p >= 0 && snd_rdy_i);
    bit tfree = (mf[mt] != 0 && mc[mt] != 0);
    int ai = int'(ack_slot_i);
    bit ahit = ack_vld_i && mf[ai] != 0 && mset[ai] == int'(ack_set_i);
    if (start_i) begin
      for (int i = 0; i < SLOTS; i++) begin mf[i] = 0; ms[i] = 0; mc[i] = 0; mset[i] = 0; end
      mh = 0; mt = 0; mfs = 0; ml = SLOTS - 1; mr = 1;
      return;
    end
    if (stop_i) mr = 0;
    if (sfire) ackq.push_back(p * 256 + mset[p]);
    if (ahit && !(tfree && mt == ai)) mc[ai] = 1;
    if (sfire && !(ffire && mh == p) && !(tfree && mt == p)) ms[p] = 1;
    if (tfree) begin mf[mt] = 0; ms[mt] = 0; mc[mt] = 0; end
    if (ffire) begin
      mf[mh] = 1; ms[mh] = 0; mc[mh] = 0; mset[mh] = mfs;
      if (mh == SLOTS - 1) mfs = (mfs + 1) % SETS;
      mh = (mh + 1) % SLOTS;
    end
    if (tfree) mt = (mt + 1) % SLOTS;
    if (sfire) ml = p;
  endtask

  task automatic cyc(bit st, bit sp, bit fr, bit av, int aset, int aslot, bit rdy);
    compare();
    start_i = st; stop_i = sp; fill_req_i = fr; snd_rdy_i = rdy;
    ack_vld_i = av; ack_set_i = SET_W'(aset); ack_slot_i = IDX_W'(aslot);
    step();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) begin mf[i] = 0; ms[i] = 0; mc[i] = 0; mset[i] = 0; end
    repeat (3) @(negedge clk);
    compare();  // R1 under reset
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 0, 0, 0, 0, 0);          // R1 idle after reset
    cyc(1, 0, 0, 0, 0, 0, 0);          // R2 start
    cyc(0, 0, 1, 0, 0, 0, 0);          // R3 fill slot 0
    cyc(0, 0, 1, 0, 0, 0, 0);          // R3 fill slot 1
    cyc(0, 0, 0, 0, 0, 0, 0);          // R10 hold on slot 0
    cyc(0, 0, 0, 0, 0, 0, 1);          // R4 hand over slot 0
    cyc(0, 0, 0, 0, 0, 0, 1);          // R4 hand over slot 1
    cyc(0, 0, 0, 1, 1, 0, 0);          // R6 wrong set ignored
    cyc(0, 0, 0, 0, 0, 0, 0);          // R5 slot 0 offered as repeat
    cyc(0, 0, 0, 1, 0, 0, 0);          // R6 good ack slot 0
    cyc(0, 0, 0, 0, 0, 0, 0);          // R7 tail frees slot 0
    cyc(1, 1, 0, 0, 0, 0, 0);          // R9 start beats stop
    cyc(0, 0, 1, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 0, 0);          // R8 stop keeps descriptors
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    ackq.delete();
    for (int n = 0; n < 6000; n++) begin
      bit st = ($urandom % 1500) == 0;
      bit sp = ($urandom % 900) == 0;
      bit fr = ($urandom % 4) != 0;
      bit rdy = ($urandom % 3) != 0;
      bit av = 0;
      int aset = 0, aslot = 0;
      if (!mr && ($urandom % 40) == 0) st = 1;
      if (ackq.size() > 0 && ($urandom % 2) == 0) begin
        int k = $urandom % ackq.size();
        int e = ackq[k];
        ackq.delete(k);
        aslot = e / 256;
        aset = e % 256;
        if (($urandom % 10) == 0) aset = (aset + 1) % SETS;  // R6 stale set
        av = ($urandom % 8) != 0;                            // dropped ack -> R5 repeat
      end
      cyc(st, sp, fr, av, aset, aslot, rdy);
    end
    compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule